// File: doc/BRIEF.md
# Counting-Ramp Conversion Sequencer

This block runs the digital side of a counting-type analog-to-digital converter. A binary count drives an external digital-to-analog converter, and an external comparator reports whether that converter's output now sits above the analog input. After a start request, the count begins at zero and climbs by one step per clock. The first code that pushes the converter output above the input ends the conversion. The result is the last code that did not exceed the input. Conversion time therefore grows with the input: small inputs finish quickly, and a full-scale input takes the whole ramp.

The comparator bit arrives from the analog domain, so it passes through a synchronizer before use. Each code that goes to the converter is carried down a matching delay line. Every comparator reading is therefore judged against the code that produced it, and the extra synchronizer cycles never shift the answer. If the ramp reaches the all-ones code without a trip, the block reports full scale. A one-cycle done flag marks every finished conversion. The result output holds its value between conversions.

Top module: `ramp_adc_ctrl`

## Requirements
- R1: Reset is asynchronous and active low. While reset is asserted, and after it is released, `done` is 0, `result` is 0, `dac_code` is 0, and the block waits idle.
- R2: When `start` is 1 in an idle cycle, the next cycle shows `dac_code` = 0 and the ramp begins. `dac_code` always shows the current count.
- R3: While ramping, `dac_code` rises by exactly one per clock. It saturates at 2^WIDTH-1 and never wraps to zero.
- R4: `cmp_above` passes through SYNC_STAGES flops. Each reading is paired with the code driven in the cycle it was sampled. For an input V, `done` is therefore high in cycle s+5+clamp(V,-1,2^WIDTH-2), where s is the cycle in which `start` was accepted and SYNC_STAGES = 2.
- R5: The conversion ends at the first code whose paired reading is 1 (1 = converter output above the input). The result is that code minus one. A trip already at code 0 gives 0.
- R6: If the all-ones code is paired with a reading of 0, the conversion ends and the result is all ones (full scale).
- R7: `done` is high for exactly one cycle per conversion, in the cycle after the decision. The block is idle in the following cycle.
- R8: `result` changes only on the edge that raises `done`. At all other times it keeps the previous conversion's value.
- R9: `start` has no effect while a conversion is ramping or signalling done. When a new conversion starts, readings left in the pipeline from the previous one are discarded.
- R10: From the decision until the next accepted start, `dac_code` stays frozen.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Conversion request, honoured only when idle |
| cmp_above | input | 1 | Comparator bit, 1 when the converter output exceeds the analog input (asynchronous) |
| dac_code | output | WIDTH | Code driven to the external converter |
| result | output | WIDTH | Last completed conversion value |
| done | output | 1 | One-cycle completion flag |

## Verification
The assertions check the following on every cycle: the step-by-one ramp and its saturation, the clear on an accepted start, the frozen code outside the ramp, the single-cycle done followed by idle, the hold of the result between loads, and the pipeline flush. They also check that the paired code at the pipeline head never runs ahead of the live count. Only the bench's scenarios can show that the value reported equals the input and that the conversion takes the expected number of cycles. These scenarios cover a trip at code zero, inputs just below and above full scale, and back-to-back conversions whose leftover comparator history would corrupt the second answer if it were not discarded.

// File: rtl/ramp_adc_pkg.sv
package ramp_adc_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_COUNT = 2'd1,
        ST_DONE  = 2'd2
    } ramp_state_e;

endpackage

// File: rtl/ramp_sync.sv
module ramp_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic sync_out
);
    logic [STAGES-1:0] sh_d;
    logic [STAGES-1:0] sh_q;

    generate
        if (STAGES == 1) begin : g_single
            always_comb sh_d = async_in;
        end else begin : g_chain
            always_comb sh_d = {sh_q[STAGES-2:0], async_in};
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= '0;
        else        sh_q <= sh_d;
    end

    assign sync_out = sh_q[STAGES-1];
endmodule

// File: rtl/ramp_code_pipe.sv
module ramp_code_pipe #(
    parameter int WIDTH  = 8,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flush,
    input  logic             push_valid,
    input  logic [WIDTH-1:0] push_code,
    output logic             head_valid,
    output logic [WIDTH-1:0] head_code
);
    logic [STAGES-1:0][WIDTH-1:0] code_d, code_q;
    logic [STAGES-1:0]            vld_d,  vld_q;

    always_comb begin
        code_d[0] = push_code;
        vld_d[0]  = push_valid;
        for (int i = 1; i < STAGES; i++) begin
            code_d[i] = code_q[i-1];
            vld_d[i]  = vld_q[i-1];
        end
        if (flush) vld_d = '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            code_q <= '0;
            vld_q  <= '0;
        end else begin
            code_q <= code_d;
            vld_q  <= vld_d;
        end
    end

    assign head_valid = vld_q[STAGES-1];
    assign head_code  = code_q[STAGES-1];

    // A new conversion must never see an old reading at the head
    assert_flush_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> !head_valid);
endmodule

// File: rtl/ramp_seq.sv
module ramp_seq
    import ramp_adc_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             head_valid,
    input  logic [WIDTH-1:0] head_code,
    input  logic             head_above,
    output logic [WIDTH-1:0] cnt,
    output logic             counting,
    output logic             accept,
    output logic             done,
    output logic             load,
    output logic [WIDTH-1:0] load_val
);
    localparam logic [WIDTH-1:0] CODE_MAX = {WIDTH{1'b1}};

    typedef struct packed {
        ramp_state_e      st;
        logic [WIDTH-1:0] cnt;
    } seq_t;

    seq_t s_d, s_q;
    logic head_trip, head_full, decide;

    always_comb begin
        head_trip = head_valid && head_above;
        head_full = head_valid && !head_above && (head_code == CODE_MAX);
        decide    = (s_q.st == ST_COUNT) && (head_trip || head_full);
        if (head_trip) load_val = (head_code == '0) ? '0 : head_code - 1'b1;
        else           load_val = CODE_MAX;

        s_d = s_q;
        unique case (s_q.st)
            ST_IDLE: begin
                if (start) begin
                    s_d.st  = ST_COUNT;
                    s_d.cnt = '0;
                end
            end
            ST_COUNT: begin
                if (decide)                 s_d.st  = ST_DONE;
                else if (s_q.cnt != CODE_MAX) s_d.cnt = s_q.cnt + 1'b1;
            end
            ST_DONE: s_d.st = ST_IDLE;
            default: s_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '{st: ST_IDLE, cnt: '0};
        else        s_q <= s_d;
    end

    assign cnt      = s_q.cnt;
    assign counting = (s_q.st == ST_COUNT);
    assign accept   = (s_q.st == ST_IDLE) && start;
    assign done     = (s_q.st == ST_DONE);
    assign load     = decide;

    assert_start_clears_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.st == ST_IDLE && start) |=> (s_q.st == ST_COUNT && s_q.cnt == '0));
    assert_step_one_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.st == ST_COUNT && !decide && s_q.cnt != CODE_MAX)
        |=> s_q.cnt == WIDTH'($past(s_q.cnt) + 1'b1));
    assert_no_wrap_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.st == ST_COUNT && s_q.cnt == CODE_MAX) |=> s_q.cnt == CODE_MAX);
    assert_done_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.st == ST_DONE) |=> (s_q.st == ST_IDLE));
    assert_busy_ignores_start_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.st == ST_COUNT && !decide) |=> (s_q.st == ST_COUNT));
    assert_code_frozen_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.st != ST_COUNT && !(s_q.st == ST_IDLE && start)) |=> $stable(s_q.cnt));
endmodule

// File: rtl/ramp_result.sv
module ramp_result #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [WIDTH-1:0] load_val,
    output logic [WIDTH-1:0] result
);
    logic [WIDTH-1:0] res_d, res_q;

    always_comb res_d = load ? load_val : res_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) res_q <= '0;
        else        res_q <= res_d;
    end

    assign result = res_q;

    assert_result_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> $stable(res_q));
endmodule

// File: rtl/ramp_adc_ctrl.sv
module ramp_adc_ctrl #(
    parameter int WIDTH       = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             cmp_above,
    output logic [WIDTH-1:0] dac_code,
    output logic [WIDTH-1:0] result,
    output logic             done
);
    logic             above_sync;
    logic             head_valid;
    logic [WIDTH-1:0] head_code;
    logic [WIDTH-1:0] cnt;
    logic             counting, accept, load;
    logic [WIDTH-1:0] load_val;

    ramp_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .async_in(cmp_above), .sync_out(above_sync)
    );

    ramp_code_pipe #(.WIDTH(WIDTH), .STAGES(SYNC_STAGES)) u_pipe (
        .clk(clk), .rst_n(rst_n), .flush(accept),
        .push_valid(counting), .push_code(cnt),
        .head_valid(head_valid), .head_code(head_code)
    );

    ramp_seq #(.WIDTH(WIDTH)) u_seq (
        .clk(clk), .rst_n(rst_n), .start(start),
        .head_valid(head_valid), .head_code(head_code), .head_above(above_sync),
        .cnt(cnt), .counting(counting), .accept(accept), .done(done),
        .load(load), .load_val(load_val)
    );

    ramp_result #(.WIDTH(WIDTH)) u_res (
        .clk(clk), .rst_n(rst_n), .load(load), .load_val(load_val), .result(result)
    );

    assign dac_code = cnt;

    // The paired code lags the live count; it can never be ahead of it
    assert_pair_lags_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (counting && head_valid) |-> (head_code <= dac_code));
endmodule

// File: tb/ramp_adc_ctrl_tb.sv
module ramp_adc_ctrl_tb;
    localparam int W    = 8;
    localparam int MAXC = (1 << W) - 1;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start = 1'b0;
    logic         cmp_above;
    logic [W-1:0] dac_code, result;
    logic         done;
    int           vin = 0;

    int n_chk = 0, n_fail = 0, cyc = 0;
    bit model_on = 1'b0;

    always #4 clk = ~clk;   // 125 MHz

    // Analog side: converter output vs. input as a threshold
    assign cmp_above = (int'(dac_code) > vin);

    ramp_adc_ctrl #(.WIDTH(W), .SYNC_STAGES(2)) u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .cmp_above(cmp_above),
        .dac_code(dac_code), .result(result), .done(done)
    );

    function automatic int clampi(int v, int lo, int hi);
        return (v < lo) ? lo : (v > hi) ? hi : v;
    endfunction

    task automatic chk(bit ok, string req, int act, int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    // Behavioural reference model
    bit m_busy = 1'b0;
    int m_j = 0, m_dn = 0, m_vin = 0;
    int e_dac = 0, e_res = 0, e_done = 0;

    always @(posedge clk) begin
        cyc++;
        if (!rst_n) begin
            m_busy = 1'b0; e_dac = 0; e_res = 0; e_done = 0;
        end else if (!m_busy) begin
            if (start) begin
                m_busy = 1'b1; m_j = 1; m_vin = vin;
                m_dn = 5 + clampi(vin, -1, MAXC - 1);
                e_dac = 0; e_done = 0;
            end
        end else begin
            m_j++;
            if (m_j <= m_dn) e_dac = clampi(((m_j < m_dn - 1) ? m_j : m_dn - 1) - 1, 0, MAXC);
            if (m_j == m_dn) begin
                e_done = 1;
                e_res  = clampi(m_vin, 0, MAXC);
            end else if (m_j == m_dn + 1) begin
                e_done = 0;
                m_busy = 1'b0;
            end
        end
    end

    // Compare every cycle, away from the active edge
    always @(negedge clk) begin
        if (model_on) begin
            chk(int'(done) == e_done, "R7 done", int'(done), e_done);
            chk(int'(result) == e_res, "R5 R6 R8 result", int'(result), e_res);
            chk(int'(dac_code) == e_dac, "R2 R3 R10 dac_code", int'(dac_code), e_dac);
        end
        if (cyc > 150000) begin
            chk(1'b0, "watchdog", cyc, 150000);
            finish_run();
        end
    end

    // One conversion; optional stray start pulse while busy (R9)
    task automatic convert(int v, bit stray);
        int c0;
        int waited;
        @(negedge clk);
        vin = v;
        start = 1'b1;
        c0 = cyc;
        @(negedge clk);
        start = 1'b0;
        waited = 0;
        while (!done && waited < 400) begin
            if (stray && waited == 3) start = 1'b1;
            @(negedge clk);
            start = 1'b0;
            waited++;
        end
        // R4: conversion length from the accepted start
        chk(cyc - c0 == 5 + clampi(v, -1, MAXC - 1), "R4 latency",
            cyc - c0, 5 + clampi(v, -1, MAXC - 1));
        chk(int'(result) == clampi(v, 0, MAXC), "R5 R6 value", int'(result), clampi(v, 0, MAXC));
        repeat (3) @(negedge clk);
        chk(int'(done) == 0, "R7 done low after", int'(done), 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state while reset asserted
        chk(done == 1'b0, "R1 done", int'(done), 0);
        chk(result == '0, "R1 result", int'(result), 0);
        chk(dac_code == '0, "R1 dac_code", int'(dac_code), 0);
        rst_n = 1'b1;
        model_on = 1'b1;
        repeat (4) @(negedge clk);
        chk(dac_code == '0 && done == 1'b0, "R1 idle after reset", int'(dac_code), 0);

        convert(37, 1'b0);
        convert(0, 1'b0);
        convert(1, 1'b0);
        convert(-1, 1'b0);          // trip at code 0 -> R5 clamp
        convert(200, 1'b1);         // stray start while busy -> R9
        convert(MAXC - 1, 1'b0);    // last trip code
        convert(MAXC, 1'b0);        // R6 full scale
        convert(400, 1'b0);         // R6 above full scale
        convert(12, 1'b0);

        // R8: result holds through idle time after a conversion
        repeat (20) @(negedge clk);
        chk(int'(result) == 12, "R8 hold", int'(result), 12);

        // R9: back-to-back with start held; stale high readings must be discarded
        @(negedge clk);
        vin = 50;
        start = 1'b1;
        while (!done) @(negedge clk);
        chk(int'(result) == 50, "R5 first of pair", int'(result), 50);
        vin = 20;
        @(negedge clk);
        @(negedge clk);
        start = 1'b0;
        while (!done) @(negedge clk);
        chk(int'(result) == 20, "R9 second of pair", int'(result), 20);
        repeat (5) @(negedge clk);
        chk(int'(dac_code) == 23, "R10 frozen code", int'(dac_code), 23);

        finish_run();
    end
endmodule